// File: doc/BRIEF.md
# Quarter-Wave Table Sine Synthesizer

This block is a direct digital synthesis sine source. A wide phase register steps forward by an unsigned frequency word on every clock while the block is running. A phase offset word is added to the upper part of that register to form a table address. The address picks one point of a sine period, and the block emits one signed sample per clock. The output frequency is `K * f_clk / 2^24`. At the nominal 15 MHz clock this gives a resolution of just under one hertz.

Only the first quarter of the period is stored. The two top address bits give the quadrant. One bit reverses the direction in which the quarter table is read, and the other negates the magnitude that comes out. Together they rebuild the whole period from a quarter-sized table. The table is filled by a constant function when the design is built, so no memory image file is needed. The DAC and the analog reconstruction path are outside this block.

While the active-low run input is high, the phase register stays at zero. The output then shows the sample at the address given by the phase word alone. When run goes low, the register starts to advance. Two instances that share a frequency word and are released in the same cycle keep a fixed phase difference equal to the difference of their phase words.

Top module: `dds_quarter_sine`

## Requirements
- R1: A synchronous active-high `rst` held for at least two clocks clears the phase register. `sample_o` reads 0 during reset and for two clocks after reset is released.
- R2: While `run_n` is high, the phase register is loaded with zero on every clock. With `phase_word` held, `sample_o` settles to the sample at address `phase_word`.
- R3: While `run_n` is low, the 24-bit phase register adds the 9-bit unsigned `freq_word` on every rising edge and wraps modulo 2^24.
- R4: The 13-bit table address is `(phase_reg[23:11] + phase_word) mod 2^13`. The 11-bit phase word is zero-extended and added at the least significant address bit.
- R5: The quarter table has 2048 entries of 8 bits. Entry i is `round(255 * sin((i + 0.5) * pi / 4096))`, and address bits [10:0] select the entry when address bits 12 and 11 are both 0.
- R6: When address bit 11 is 1, the entry read is `2047 - a[10:0]` (bitwise complement of the index). This reads the quarter backwards.
- R7: When address bit 12 is 1, `sample_o` is the two's-complement negative of the table entry. Otherwise it is the entry itself. `sample_o` is 9 bits wide and never equals -256.
- R8: A change on `phase_word` that is sampled at clock edge n first shows on `sample_o` after edge n+2. Earlier samples still reflect the old word.
- R9: Over a full period, the samples at addresses a and a+4096 are exact negatives of each other. Samples at neighbouring addresses, including across the four quadrant seams, differ by at most 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| run_n | input | 1 | Low lets the phase register advance; high holds it at zero |
| freq_word | input | 9 | Unsigned phase increment per clock |
| phase_word | input | 11 | Phase offset added at the address LSB |
| sample_o | output | 9 | Signed two's-complement sine sample |

## Verification
The hardest behaviour to reach from the ports is the set of quadrant seams and the half-period symmetry. The phase word alone only reaches the first quarter of the address space. Every other address must come from the running phase register. The stimulus therefore runs the largest frequency word for a little more than one full period of the 24-bit register. That step is below one address per clock, so every one of the 8192 addresses is visited, and the register also wraps. The bench records each address with its observed sample, then checks negation across half a period and continuity at every neighbour pair, including the seams.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // Magnitude of one quarter-period entry, rounded to nearest.
  function automatic int unsigned quarter_sine(input int unsigned idx,
                                               input int unsigned depth,
                                               input int unsigned amp_w);
    real full_scale;
    real angle;
    full_scale = real'((1 << amp_w) - 1);
    angle      = (real'(idx) + 0.5) * PI_R / (2.0 * real'(depth));
    return int'($rtoi(full_scale * $sin(angle) + 0.5));
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W   = 24,
  parameter int FREQ_W  = 9,
  parameter int PHASE_W = 11,
  parameter int ADDR_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_n,
  input  logic [FREQ_W-1:0] freq_word,
  input  logic [PHASE_W-1:0] phase_word,
  output logic [ACC_W-1:0]  acc_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ACC_W-1:0]  acc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  // Offset enters at the least significant address bit.
  assign addr_d = acc_q[ACC_W-1 -: ADDR_W] + ADDR_W'(phase_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
      if (run_n) acc_q <= '0;
      else       acc_q <= acc_q + ACC_W'(freq_word);
    end
  end

  assign acc_o  = acc_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/dds_quadrant_rom.sv
module dds_quadrant_rom #(
  parameter int ADDR_W = 13,
  parameter int AMP_W  = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [AMP_W-1:0]  mag_o,
  output logic              neg_o
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  logic [AMP_W-1:0] table_q [DEPTH];
  logic [IDX_W-1:0] raw_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             mirror;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      table_q[i] = AMP_W'(dds_pkg::quarter_sine(i, DEPTH, AMP_W));
    end
  end

  assign raw_idx = addr_i[IDX_W-1:0];
  assign mirror  = addr_i[IDX_W];
  assign rd_idx  = mirror ? ~raw_idx : raw_idx;

  // Unreset read register so the table maps onto a block RAM.
  always_ff @(posedge clk) begin
    mag_o <= table_q[rd_idx];
    neg_o <= addr_i[ADDR_W-1];
  end

endmodule

// File: rtl/dds_sign_stage.sv
module dds_sign_stage #(
  parameter int AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AMP_W-1:0] mag_i,
  input  logic             neg_i,
  output logic [AMP_W:0]   sample_o
);

  logic [AMP_W:0] mag_ext;

  assign mag_ext = {1'b0, mag_i};

  always_ff @(posedge clk) begin
    if (rst)        sample_o <= '0;
    else if (neg_i) sample_o <= -mag_ext;
    else            sample_o <= mag_ext;
  end

endmodule

// File: rtl/dds_quarter_sine.sv
module dds_quarter_sine #(
  parameter int ACC_W   = 24,
  parameter int FREQ_W  = 9,
  parameter int PHASE_W = 11,
  parameter int ADDR_W  = 13,
  parameter int AMP_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_n,
  input  logic [FREQ_W-1:0]  freq_word,
  input  logic [PHASE_W-1:0] phase_word,
  output logic [AMP_W:0]     sample_o
);

  logic [ACC_W-1:0]  acc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AMP_W-1:0]  mag_q;
  logic              neg_q;

  dds_phase_acc #(
    .ACC_W(ACC_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W)
  ) acc_i (
    .clk(clk), .rst(rst), .run_n(run_n), .freq_word(freq_word),
    .phase_word(phase_word), .acc_o(acc_q), .addr_o(addr_q)
  );

  dds_quadrant_rom #(
    .ADDR_W(ADDR_W), .AMP_W(AMP_W)
  ) rom_i (
    .clk(clk), .addr_i(addr_q), .mag_o(mag_q), .neg_o(neg_q)
  );

  dds_sign_stage #(
    .AMP_W(AMP_W)
  ) sign_i (
    .clk(clk), .rst(rst), .mag_i(mag_q), .neg_i(neg_q), .sample_o(sample_o)
  );

endmodule

// File: rtl/dds_quarter_sine_chk.sv
module dds_quarter_sine_chk #(
  parameter int ACC_W   = 24,
  parameter int FREQ_W  = 9,
  parameter int PHASE_W = 11,
  parameter int ADDR_W  = 13,
  parameter int AMP_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               run_n,
  input logic [FREQ_W-1:0]  freq_word,
  input logic [PHASE_W-1:0] phase_word,
  input logic [ACC_W-1:0]   acc_q,
  input logic [ADDR_W-1:0]  addr_q,
  input logic [AMP_W:0]     sample_o
);

  localparam logic [AMP_W:0] MOST_NEG = {1'b1, {AMP_W{1'b0}}};

  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  AST_RUN_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    run_n |=> (acc_q == '0)); // R2

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    !run_n |=> (acc_q == $past(acc_q) + ACC_W'($past(freq_word)))); // R3

  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (rst)
    sample_o != MOST_NEG); // R7

  AST_POS_HALF_SIGN: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && !$past(addr_q[ADDR_W-1], 2)) |-> !sample_o[AMP_W]); // R7

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd6 && $past(run_n, 4) && $past(run_n, 5) &&
     $past(phase_word, 3) == $past(phase_word, 4)) |-> $stable(sample_o)); // R2

endmodule

bind dds_quarter_sine dds_quarter_sine_chk #(
  .ACC_W(ACC_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W)
) chk_i (
  .clk(clk), .rst(rst), .run_n(run_n), .freq_word(freq_word),
  .phase_word(phase_word), .acc_q(acc_q), .addr_q(addr_q), .sample_o(sample_o)
);

// File: tb/dds_quarter_sine_tb_top.sv
module dds_quarter_sine_tb_top;

  localparam real PI_R = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_n = 1'b1;
  logic [8:0]  freq_word = '0;
  logic [10:0] phase_word = '0;
  logic [8:0]  sample_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  // Behavioural reference state.
  longint    m_acc = 0;
  int        m_q[$];
  int        m_exp = 0;
  int        m_addr = -1;
  int        seen[int];

  always #4 clk = ~clk;

  dds_quarter_sine dut_i (
    .clk(clk), .rst(rst), .run_n(run_n), .freq_word(freq_word),
    .phase_word(phase_word), .sample_o(sample_o)
  );

  function automatic int ref_sample(input int a);
    int i;
    int m;
    i = a % 2048;
    if (((a / 2048) % 2) == 1) i = 2047 - i;            // R6
    m = int'($rtoi(255.0 * $sin((real'(i) + 0.5) * PI_R / 4096.0) + 0.5)); // R5
    return (a >= 4096) ? -m : m;                         // R7
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int out_val();
    return int'($signed(sample_o));
  endfunction

  // Model: three-register latency from address formation to output (R8).
  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0;
      m_q.delete();
      m_exp = 0;
      m_addr = -1;
    end else begin
      m_q.push_back(int'(((m_acc >> 11) + longint'(phase_word)) % 8192)); // R4
      if (m_q.size() > 3) void'(m_q.pop_front());
      if (run_n) m_acc = 0;                                                // R2
      else       m_acc = (m_acc + longint'(freq_word)) % 64'd16777216;    // R3
      if (m_q.size() == 3) begin
        m_addr = m_q[0];
        m_exp  = ref_sample(m_addr);
      end else begin
        m_addr = -1;
        m_exp  = 0;                                                        // R1
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      if (m_addr < 0)
        check(out_val() == 0, "R1 flush", out_val(), 0);
      else begin
        if (m_addr >= 4096)      check(out_val() == m_exp, "R7 sample", out_val(), m_exp);
        else if (m_addr >= 2048) check(out_val() == m_exp, "R6 sample", out_val(), m_exp);
        else                     check(out_val() == m_exp, "R5 sample", out_val(), m_exp);
        seen[m_addr] = out_val();
      end
    end
  end

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    int hold_val;
    cycles(3);
    check(out_val() == 0, "R1 reset", out_val(), 0);
    rst = 1'b0;

    // Held phase register: address comes from phase word only.
    phase_word = 11'd180;
    cycles(6);
    check(out_val() == ref_sample(180), "R2 held", out_val(), ref_sample(180));

    // Latency of a phase change.
    phase_word = 11'd1000;
    cycles(2);
    check(out_val() == ref_sample(180), "R8 old", out_val(), ref_sample(180));
    cycles(1);
    check(out_val() == ref_sample(1000), "R8 new", out_val(), ref_sample(1000));

    // Running with several words.
    run_n = 1'b0;
    freq_word = 9'd50;
    cycles(200);
    phase_word = 11'd2047;
    freq_word = 9'd300;
    cycles(150);
    phase_word = 11'd3;
    freq_word = 9'd1;
    cycles(50);

    // Stop: register returns to zero, output settles (R2).
    run_n = 1'b1;
    phase_word = 11'd700;
    cycles(8);
    hold_val = out_val();
    check(hold_val == ref_sample(700), "R2 stop", hold_val, ref_sample(700));

    // Mid-run reset.
    run_n = 1'b0;
    freq_word = 9'd400;
    cycles(20);
    rst = 1'b1;
    cycles(3);
    check(out_val() == 0, "R1 midrun", out_val(), 0);
    rst = 1'b0;

    // Full sweep past one wrap of the 24-bit register (R3).
    seen.delete();
    phase_word = 11'd0;
    freq_word = 9'd511;
    run_n = 1'b0;
    cycles(34000);

    // Half-period negation and neighbour continuity (R9).
    for (int a = 0; a < 8192; a++) begin
      if (!seen.exists(a)) begin
        check(1'b0, "R9 coverage", a, 1);
      end else begin
        int b;
        int d;
        b = (a + 1) % 8192;
        if (a < 4096 && seen.exists(a + 4096))
          check(seen[a + 4096] == -seen[a], "R9 negation", seen[a + 4096], -seen[a]);
        if (seen.exists(b)) begin
          d = seen[b] - seen[a];
          check(d <= 1 && d >= -1, "R9 continuity", d, 0);
        end
      end
    end
    check(seen.exists(2047) && seen.exists(2048) && seen[2047] == 255 && seen[2048] == 255,
          "R6 seam", seen.exists(2048) ? seen[2048] : -999, 255);
    check(seen.exists(4096) && seen[4096] == 0, "R7 zero crossing",
          seen.exists(4096) ? seen[4096] : -999, 0);
    check(seen.exists(6144) && seen[6144] == -255, "R7 trough",
          seen.exists(6144) ? seen[6144] : -999, -255);

    cycles(2);
    finish_run();
  end

endmodule